// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose writer and reader run on separate clocks. Words enter on the write clock while the write enable is high. They leave in the same order on the read clock while the read enable is high. The read word is registered and appears on the read data bus after the read edge that takes it.

Five active-low status flags describe how full the buffer is: full, almost-full, half-full, almost-empty and empty. Full, almost-full and half-full are produced in the write clock domain. Empty and almost-empty are produced in the read clock domain. Each side sees the other side's pointer through a Gray-coded, two-stage synchroniser.

The almost-full margin and the almost-empty margin are held in a small offset register pair. Each register is reloaded from its own clock domain and returns to a parameter default on reset. As a result, a flag asserts on the same edge as the operation on its own side that causes it. It releases a few cycles after the opposite side's operation that clears it.

Top module: `pflag_fifo`

## Requirements
- R1: While and after reset, with no traffic, fullN, afN and hfN are 1 and emptyN and aeN are 0; both offsets return to DEF_OFS.
- R2: fullN is 0 exactly when the buffer holds DEPTH = 2**ADDR_W words. A write requested while fullN is 0 stores nothing and does not displace stored words.
- R3: emptyN is 0 exactly when the buffer holds no word. A read requested while emptyN is 0 leaves rdata unchanged and consumes nothing.
- R4: afN is 0 exactly when the word count is at least DEPTH minus the full offset m.
- R5: aeN is 0 exactly when the word count is at most the empty offset n, and 1 for n+1 words or more.
- R6: hfN is 0 exactly when the word count exceeds DEPTH/2.
- R7: A high ofsFullLd on a wclk edge loads ofsFullVal as m. A high ofsEmptyLd on an rclk edge loads ofsEmptyVal as n. The thresholds follow the new values.
- R8: Words are read back in write order. rdata takes the read word on the rclk edge that performs the read and holds it until the next read.
- R9: A flag's own-side update takes effect on the same clock edge as the write (for fullN, afN, hfN) or the read (for emptyN, aeN) that changes the count. Updates caused by the opposite side are visible within six clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wen | input | 1 | Write request, sampled on wclk |
| wdata | input | DATA_W | Word to write |
| ren | input | 1 | Read request, sampled on rclk |
| rdata | output | DATA_W | Registered read word |
| ofsFullLd | input | 1 | Load strobe for the almost-full margin (wclk) |
| ofsFullVal | input | ADDR_W | New almost-full margin m |
| ofsEmptyLd | input | 1 | Load strobe for the almost-empty margin (rclk) |
| ofsEmptyVal | input | ADDR_W | New almost-empty margin n |
| fullN | output | 1 | Active-low full |
| afN | output | 1 | Active-low almost-full |
| hfN | output | 1 | Active-low half-full |
| emptyN | output | 1 | Active-low empty |
| aeN | output | 1 | Active-low almost-empty |

## Verification
The flag-ordering properties assume that the margins stay below DEPTH, which the offset port width guarantees. The rdata hold property assumes that reset is the only other event that changes rdata. The bench drives both clocks in phase and changes inputs on falling edges only. Before it samples any cross-domain flag, it lets the synchronisers settle for six clocks. Own-side flags are sampled right after the operation that moves them, so the late release never meets a check that expects the early one.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrDo;
    logic rdDo;
  } fifoStb_t;
endpackage

// File: rtl/pflag_fifo_ofs.sv
module pflag_fifo_ofs #(
  parameter int OFS_W   = 10,
  parameter int DEF_OFS = 127
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rstN,
  input  logic             ldFull,
  input  logic [OFS_W-1:0] fullVal,
  input  logic             ldEmpty,
  input  logic [OFS_W-1:0] emptyVal,
  output logic [OFS_W-1:0] fullOfs,
  output logic [OFS_W-1:0] emptyOfs
);
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  // margin for the write-side threshold lives in the write domain
  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN)       fullOfs <= DEF_V;
    else if (ldFull) fullOfs <= fullVal;
  end

  // margin for the read-side threshold lives in the read domain
  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)        emptyOfs <= DEF_V;
    else if (ldEmpty) emptyOfs <= emptyVal;
  end
endmodule

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pflag_fifo_ctrl.sv
module pflag_fifo_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wen,
  input  logic              ren,
  input  logic [ADDR_W-1:0] fullOfs,
  input  logic [ADDR_W-1:0] emptyOfs,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              afN,
  output logic              hfN,
  output logic              emptyN,
  output logic              aeN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain state
  logic [PTR_W-1:0] wBin, wGray, wBinNext, rGraySyncW, rBinSyncW, wCntNext, afLimit;
  // read domain state
  logic [PTR_W-1:0] rBin, rGray, rBinNext, wGraySyncR, wBinSyncR, rCntNext;

  assign stb.wrDo = wen & fullN;
  assign stb.rdDo = ren & emptyN;
  assign wrAddr   = wBin[ADDR_W-1:0];
  assign rdAddr   = rBin[ADDR_W-1:0];

  pflag_fifo_sync #(.W(PTR_W)) uSyncR2W (
    .clk(wclk), .rstN(rstN), .d(rGray), .q(rGraySyncW)
  );
  pflag_fifo_sync #(.W(PTR_W)) uSyncW2R (
    .clk(rclk), .rstN(rstN), .d(wGray), .q(wGraySyncR)
  );

  // ---------------- write side ----------------
  always_comb begin
    wBinNext  = wBin + PTR_W'(stb.wrDo);
    rBinSyncW = fromGray(rGraySyncW);
    wCntNext  = wBinNext - rBinSyncW;
    afLimit   = DEPTH_P - {1'b0, fullOfs};
  end

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
      fullN <= 1'b1;
      afN   <= 1'b1;
      hfN   <= 1'b1;
    end else begin
      wBin  <= wBinNext;
      wGray <= toGray(wBinNext);
      fullN <= (wCntNext != DEPTH_P);
      afN   <= (wCntNext < afLimit);
      hfN   <= (wCntNext <= HALF_P);
    end
  end

  // ---------------- read side ----------------
  always_comb begin
    rBinNext  = rBin + PTR_W'(stb.rdDo);
    wBinSyncR = fromGray(wGraySyncR);
    rCntNext  = wBinSyncR - rBinNext;
  end

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN) begin
      rBin   <= '0;
      rGray  <= '0;
      emptyN <= 1'b0;
      aeN    <= 1'b0;
    end else begin
      rBin   <= rBinNext;
      rGray  <= toGray(rBinNext);
      emptyN <= (rCntNext != '0);
      aeN    <= (rCntNext > {1'b0, emptyOfs});
    end
  end
endmodule

// File: rtl/pflag_fifo_dpath.sv
module pflag_fifo_dpath
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (stb.wrDo) mem[wrAddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (stb.rdDo)  rdata <= mem[rdAddr];
  end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 10,
  parameter int DEF_OFS = 127
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  input  logic              ofsFullLd,
  input  logic [ADDR_W-1:0] ofsFullVal,
  input  logic              ofsEmptyLd,
  input  logic [ADDR_W-1:0] ofsEmptyVal,
  output logic              fullN,
  output logic              afN,
  output logic              hfN,
  output logic              emptyN,
  output logic              aeN
);
  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, fullOfs, emptyOfs;

  pflag_fifo_ofs #(.OFS_W(ADDR_W), .DEF_OFS(DEF_OFS)) uOfs (
    .wclk(wclk), .rclk(rclk), .rstN(rstN),
    .ldFull(ofsFullLd), .fullVal(ofsFullVal),
    .ldEmpty(ofsEmptyLd), .emptyVal(ofsEmptyVal),
    .fullOfs(fullOfs), .emptyOfs(emptyOfs)
  );

  pflag_fifo_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wclk(wclk), .rclk(rclk), .rstN(rstN),
    .wen(wen), .ren(ren),
    .fullOfs(fullOfs), .emptyOfs(emptyOfs),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .afN(afN), .hfN(hfN), .emptyN(emptyN), .aeN(aeN)
  );

  pflag_fifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .wclk(wclk), .rclk(rclk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int DATA_W = 18
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rstN,
  input logic              ren,
  input logic              rdDo,
  input logic [DATA_W-1:0] rdata,
  input logic              fullN,
  input logic              afN,
  input logic              hfN,
  input logic              emptyN,
  input logic              aeN
);
  AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!rstN)
    !fullN |-> !afN); // R4

  AST_FULL_IMPLIES_HF: assert property (@(posedge wclk) disable iff (!rstN)
    !fullN |-> !hfN); // R6

  AST_AF_AT_FULL_ENTRY: assert property (@(posedge wclk) disable iff (!rstN)
    $fell(fullN) |-> !afN); // R2

  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!rstN)
    !emptyN |-> !aeN); // R5

  AST_EMPTY_READ_HOLDS: assert property (@(posedge rclk) disable iff (!rstN)
    (!emptyN && ren) |=> $stable(rdata)); // R3

  AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rstN)
    !rdDo |=> $stable(rdata)); // R8
endmodule

bind pflag_fifo pflag_fifo_chk #(.DATA_W(DATA_W)) uChk (
  .wclk(wclk), .rclk(rclk), .rstN(rstN), .ren(ren), .rdDo(stb.rdDo),
  .rdata(rdata), .fullN(fullN), .afN(afN), .hfN(hfN),
  .emptyN(emptyN), .aeN(aeN)
);

// File: tb/sim_pflag_fifo.sv
module sim_pflag_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 18;
  localparam int ADDR_W  = 5;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int DEF_OFS = 7;
  localparam int STEPS   = 15;
  // {writes, reads} per step
  localparam int VEC [STEPS][2] = '{
    '{7, 0}, '{1, 0}, '{8, 0}, '{1, 0}, '{7, 0}, '{1, 0}, '{6, 0}, '{1, 0},
    '{2, 0}, '{0, 1}, '{0, 7}, '{0, 8}, '{0, 9}, '{0, 7}, '{0, 2}
  };

  logic wclk = 1'b0, rclk = 1'b0, rstN = 1'b0;
  logic wen = 1'b0, ren = 1'b0, ofsFullLd = 1'b0, ofsEmptyLd = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [ADDR_W-1:0] ofsFullVal = '0, ofsEmptyVal = '0;
  logic [DATA_W-1:0] rdata;
  logic fullN, afN, hfN, emptyN, aeN;

  int total = 0, bad = 0, mCnt = 0, curM = DEF_OFS, curN = DEF_OFS;
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] seed = 18'h2a5c1;
  bit done = 0;

  always #(CLK_PERIOD / 2) begin
    wclk = ~wclk;
    rclk = ~rclk;
  end

  pflag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u0 (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .wen(wen), .wdata(wdata),
    .ren(ren), .rdata(rdata), .ofsFullLd(ofsFullLd), .ofsFullVal(ofsFullVal),
    .ofsEmptyLd(ofsEmptyLd), .ofsEmptyVal(ofsEmptyVal),
    .fullN(fullN), .afN(afN), .hfN(hfN), .emptyN(emptyN), .aeN(aeN)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h count=%0d", req, what, act, exp, mCnt);
    end
  endtask

  task automatic checkW(string tag);
    chk(tag == "" ? "R2" : tag, "fullN", fullN, mCnt != DEPTH);
    chk(tag == "" ? "R4" : tag, "afN", afN, mCnt < DEPTH - curM);
    chk(tag == "" ? "R6" : tag, "hfN", hfN, mCnt <= DEPTH / 2);
  endtask

  task automatic checkR(string tag);
    chk(tag == "" ? "R3" : tag, "emptyN", emptyN, mCnt != 0);
    chk(tag == "" ? "R5" : tag, "aeN", aeN, mCnt > curN);
  endtask

  task automatic settleAll();
    repeat (6) @(negedge wclk);
    checkW("");
    checkR("");
  endtask

  task automatic doWrites(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk);
      wen = 1'b1;
      wdata = seed;
      if (mCnt < DEPTH) begin
        q.push_back(seed);
        mCnt++;
      end
      seed = {seed[DATA_W-2:0], seed[DATA_W-1] ^ seed[10]} + 18'd3;
      @(posedge wclk);
    end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic doReads(int k);
    logic [DATA_W-1:0] expD = '0;
    bit pend = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      if (pend) chk("R8", "rdata", rdata, expD);
      ren = 1'b1;
      if (mCnt > 0) begin
        expD = q.pop_front();
        mCnt--;
      end else begin
        expD = rdata; // R3: read while empty must not change rdata
      end
      pend = 1;
      @(posedge rclk);
    end
    @(negedge rclk);
    ren = 1'b0;
    if (pend) chk("R8", "rdata", rdata, expD);
  endtask

  task automatic doReset();
    @(negedge wclk);
    rstN = 1'b0;
    q.delete();
    mCnt = 0;
    curM = DEF_OFS;
    curN = DEF_OFS;
    repeat (2) @(negedge wclk);
    checkW("R1");
    checkR("R1");
    chk("R1", "rdata", rdata, 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    settleAll();

    // table walk: fills to full past every threshold, then drains past empty
    for (int s = 0; s < STEPS; s++) begin
      if (VEC[s][0] > 0) begin
        doWrites(VEC[s][0]);
        checkW("R9");
      end
      if (VEC[s][1] > 0) begin
        doReads(VEC[s][1]);
        checkR("R9");
      end
      settleAll();
    end

    // R7: runtime margins m=2, n=4
    @(negedge wclk);
    ofsFullLd = 1'b1;  ofsFullVal = 5'd2;
    ofsEmptyLd = 1'b1; ofsEmptyVal = 5'd4;
    @(negedge wclk);
    ofsFullLd = 1'b0;  ofsEmptyLd = 1'b0;
    curM = 2;
    curN = 4;
    doWrites(29);
    settleAll();
    chk("R7", "afN at 29 with m=2", afN, 1);
    doWrites(1);
    chk("R7", "afN at 30 with m=2", afN, 0);
    settleAll();
    doReads(25);
    settleAll();
    chk("R7", "aeN at 5 with n=4", aeN, 1);
    doReads(1);
    chk("R7", "aeN at 4 with n=4", aeN, 0);
    settleAll();

    // reset restores default margins
    doReset();
    settleAll();
    doWrites(24);
    chk("R7", "afN at 24 after reset", afN, 1);
    doWrites(1);
    chk("R7", "afN at 25 after reset", afN, 0);
    settleAll();
    doReads(25);
    settleAll();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule